// File: doc/BRIEF.md
# Strobe-Addressed One-Bit Dynamic Memory Core

This block is a clocked model of a one-bit-wide dynamic memory whose word address arrives in two halves over a shared address bus. A falling row strobe latches the upper half. A falling column strobe latches the lower half and starts the access. The write-enable level at that moment, or a later falling edge on write enable, selects the kind of cycle.

All strobe, address and data pins are treated as asynchronous. They pass through a short synchroniser onto a fast system clock, and edges are found by comparing each synchronised strobe with its value one clock earlier. Output data is qualified by a valid flag that stands in for a three-state driver. A separate flag marks the output as undefined after a write whose timing collides with a read already in progress.

The storage depth is a parameter. The word index is the low log2(DEPTH) bits of {row, column}.

Top module: `dram_bit_core`

## Requirements
- R1: A row-strobe fall while the column strobe is high latches `addr` as the row. A column-strobe fall while the row strobe is low latches `addr` as the column. The cell used is bits [log2(DEPTH)-1:0] of {row, column}.
- R2: Once the column strobe has been high for four consecutive clock samples, `dout_en` and `dout_x` are both 0, whatever the row strobe does.
- R3: In a read cycle, write enable is high when the column strobe falls. `dout_en` rises on the fourth clock edge after the column-strobe fall reaches the pins, carrying the addressed cell. Both stay unchanged while the column strobe remains low.
- R4: In an early write, write enable is already low when the column strobe falls. `din` is stored into the addressed cell, and `dout_en` stays 0 for the whole cycle.
- R5: In a read-modify-write, write enable falls while `dout_en` is 1. `dout` keeps the old cell value, and the `din` present at the write-enable fall is stored.
- R6: In a delayed write, write enable reaches the pins one clock after the column strobe, before read data is valid. `din` is stored, `dout_en` stays 0 and `dout_x` goes to 1 until the column strobe rises.
- R7: A cycle with only the row strobe low refreshes and leaves `dout_en` at 0. A cycle with only the column strobe low leaves `dout_en` at 0 and writes nothing, even with write enable low.
- R8: Hidden refresh: with the column strobe held low after a read, the row strobe may rise and fall again. This leaves `dout` and `dout_en` unchanged.
- R9: Page mode: while the row strobe stays low, each new column-strobe fall accesses a new column in the row already latched. Reads and early writes are both allowed.
- R10: Synchronous active-high reset clears `dout`, `dout_en` and `dout_x` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address half |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, 0 when not valid |
| dout_en | output | 1 | Read data is being driven |
| dout_x | output | 1 | Output undefined after a delayed write |

## Verification
A pin change takes two synchroniser edges and one edge-detect register before the controller acts on it. The memory read adds one more register. Read data and the rise of `dout_en` therefore appear four edges after the column strobe falls at the pins, and the drop of `dout_en` and `dout_x` after a column-strobe rise is also due within four edges. The bench drives all pins on falling clock edges and waits six falling edges before it compares any output, so every result has settled before sampling. The delayed-write case depends on write enable arriving exactly one clock after the column strobe, and the bench times that step to the edge.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_READ,
    CYC_EARLY,
    CYC_RMW,
    CYC_DELAYED,
    CYC_CAS_ONLY
  } cyc_kind_t;
endpackage

// File: rtl/dram_sync.sv
module dram_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else if (i == 0) st[i] <= d;
        else st[i] <= st[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          wd,
  output logic          rd
);
  localparam int WORDS = 2**AW;

  logic mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_ras,
  input  logic              s_cas,
  input  logic              s_we,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              s_din,
  input  logic              rd_data,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_wd,
  output logic              dout,
  output logic              dout_en,
  output logic              dout_x
);
  localparam int FULL_W = 2*ADDR_W;

  logic              p_ras, p_cas, p_we;
  logic [ADDR_W-1:0] row_q, col_q;
  cyc_kind_t         kind;
  logic              pend;

  logic ras_fall, cas_fall, cas_rise, we_fall;
  logic access, rmw_go, dly_go;
  logic [FULL_W-1:0] full_sel;

  always_comb begin
    ras_fall = p_ras & ~s_ras;
    cas_fall = p_cas & ~s_cas;
    cas_rise = ~p_cas & s_cas;
    we_fall  = p_we & ~s_we;
    access   = cas_fall & ~s_ras;
    rmw_go   = we_fall & ~s_cas & ~s_ras & (kind == CYC_READ) & dout_en;
    dly_go   = we_fall & ~s_cas & ~s_ras & (kind == CYC_READ) & pend;
    full_sel = access ? {row_q, s_addr} : {row_q, col_q};
    mem_addr = full_sel[AW-1:0];
    mem_we   = (access & ~s_we) | rmw_go | dly_go;
    mem_wd   = s_din;
  end

  generate
    if (AW < FULL_W) begin : g_trunc
      logic unused_hi_bits;
      assign unused_hi_bits = ^full_sel[FULL_W-1:AW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      p_ras   <= 1'b1;
      p_cas   <= 1'b1;
      p_we    <= 1'b1;
      row_q   <= '0;
      col_q   <= '0;
      kind    <= CYC_IDLE;
      pend    <= 1'b0;
      dout    <= 1'b0;
      dout_en <= 1'b0;
      dout_x  <= 1'b0;
    end else begin
      p_ras <= s_ras;
      p_cas <= s_cas;
      p_we  <= s_we;
      // a row fall under a held column strobe is a hidden refresh: row kept
      if (ras_fall && s_cas) row_q <= s_addr;
      if (access) begin
        col_q <= s_addr;
        kind  <= s_we ? CYC_READ : CYC_EARLY;
        pend  <= s_we;
      end else if (cas_fall) begin
        kind <= CYC_CAS_ONLY;
      end
      if (pend) begin
        pend    <= 1'b0;
        dout_en <= 1'b1;
        dout    <= rd_data;
      end
      if (rmw_go) kind <= CYC_RMW;
      if (dly_go) begin
        kind    <= CYC_DELAYED;
        dout_en <= 1'b0;
        dout    <= 1'b0;
        dout_x  <= 1'b1;
      end
      if (cas_rise) begin
        kind    <= CYC_IDLE;
        pend    <= 1'b0;
        dout    <= 1'b0;
        dout_en <= 1'b0;
        dout_x  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_bit_core.sv
module dram_bit_core #(
  parameter int ADDR_W      = 8,
  parameter int DEPTH       = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  output logic              dout_x
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PIN_W = ADDR_W + 4;
  localparam logic [PIN_W-1:0] PIN_RST = {3'b111, 1'b0, {ADDR_W{1'b0}}};

  logic [PIN_W-1:0]  pins_s;
  logic              s_ras, s_cas, s_we, s_din;
  logic [ADDR_W-1:0] s_addr;
  logic              mem_we, mem_wd, rd_data;
  logic [AW-1:0]     mem_addr;

  dram_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ras_n, cas_n, we_n, din, addr}),
    .q   (pins_s)
  );

  assign {s_ras, s_cas, s_we, s_din, s_addr} = pins_s;

  dram_ctrl #(.ADDR_W(ADDR_W), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .s_ras    (s_ras),
    .s_cas    (s_cas),
    .s_we     (s_we),
    .s_addr   (s_addr),
    .s_din    (s_din),
    .rd_data  (rd_data),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wd   (mem_wd),
    .dout     (dout),
    .dout_en  (dout_en),
    .dout_x   (dout_x)
  );

  dram_cell_array #(.AW(AW)) u_cells (
    .clk  (clk),
    .we   (mem_we),
    .addr (mem_addr),
    .wd   (mem_wd),
    .rd   (rd_data)
  );
endmodule

// File: rtl/dram_bit_core_chk.sv
module dram_bit_core_chk (
  input logic clk,
  input logic rst,
  input logic cas_n,
  input logic we_n,
  input logic dout,
  input logic dout_en,
  input logic dout_x
);
  AST_OFF_WHEN_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cas_n && $past(cas_n) && $past(cas_n, 2) && $past(cas_n, 3)) |-> !dout_en); // R2

  AST_X_CLEARS_WHEN_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cas_n && $past(cas_n) && $past(cas_n, 2) && $past(cas_n, 3)) |-> !dout_x); // R6

  AST_X_NOT_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    !(dout_en && dout_x)); // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(dout_en)) |-> $stable(dout)); // R3

  AST_EN_NEEDS_CAS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_en) |-> !$past(cas_n, 4)); // R3

  AST_NO_EN_ON_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_en) |-> $past(we_n, 4)); // R4
endmodule

bind dram_bit_core dram_bit_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cas_n   (cas_n),
  .we_n    (we_n),
  .dout    (dout),
  .dout_en (dout_en),
  .dout_x  (dout_x)
);

// File: tb/tb_dram_bit_core.sv
module tb_dram_bit_core;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic dout, dout_en, dout_x;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    bit en;
    bit x;
    bit d;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  always #2.5 clk = ~clk;

  dram_bit_core #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .dout_x(dout_x)
  );

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_run++;
        if (dout_en !== e.en || dout_x !== e.x || dout !== e.d) begin
          n_fail++;
          $display("FAIL %s: en/x/d actual %b%b%b expected %b%b%b",
                   e.tag, dout_en, dout_x, dout, e.en, e.x, e.d);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input bit en, input bit x, input bit d);
    exp_t e;
    e.tag = tag; e.en = en; e.x = x; e.d = d;
    exp_q.push_back(e);
    -> chk_ev;
    #0;
  endtask

  task automatic open_row(input logic [ADDR_W-1:0] row);
    addr = row; ras_n = 1'b0; cyc(3);
  endtask

  task automatic col_read(input logic [ADDR_W-1:0] col);
    addr = col; we_n = 1'b1; cas_n = 1'b0; cyc(6);
  endtask

  task automatic col_write(input logic [ADDR_W-1:0] col, input bit d);
    addr = col; din = d; we_n = 1'b0; cas_n = 1'b0; cyc(6);
  endtask

  task automatic cas_up();
    cas_n = 1'b1; we_n = 1'b1; cyc(6);
  endtask

  task automatic close_all();
    cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; cyc(6);
  endtask

  task automatic early_write(input logic [ADDR_W-1:0] row, input logic [ADDR_W-1:0] col, input bit d);
    open_row(row); col_write(col, d);
    expect_out("R4 early write keeps output off", 1'b0, 1'b0, 1'b0);
    close_all();
  endtask

  task automatic read_check(input string tag, input logic [ADDR_W-1:0] row,
                            input logic [ADDR_W-1:0] col, input bit d);
    open_row(row); col_read(col);
    expect_out(tag, 1'b1, 1'b0, d);
    close_all();
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(2);
    expect_out("R10 reset state", 1'b0, 1'b0, 1'b0);

    early_write(8'd2, 8'd5, 1'b1);
    early_write(8'd2, 8'd6, 1'b0);
    early_write(8'd7, 8'd5, 1'b0);
    early_write(8'd7, 8'd6, 1'b1);

    read_check("R1 row2 col5", 8'd2, 8'd5, 1'b1);
    read_check("R1 row2 col6", 8'd2, 8'd6, 1'b0);
    read_check("R1 row7 col5", 8'd7, 8'd5, 1'b0);

    // R3 read held while column strobe stays low, then R2 release
    open_row(8'd7); col_read(8'd6);
    expect_out("R3 read data valid", 1'b1, 1'b0, 1'b1);
    cyc(10);
    expect_out("R3 read data held", 1'b1, 1'b0, 1'b1);
    close_all();
    expect_out("R2 output off after column strobe high", 1'b0, 1'b0, 1'b0);

    // R9 page mode
    open_row(8'd2);
    col_read(8'd5);
    expect_out("R9 page col5", 1'b1, 1'b0, 1'b1);
    cas_up();
    expect_out("R2 off between page columns", 1'b0, 1'b0, 1'b0);
    col_read(8'd6);
    expect_out("R9 page col6", 1'b1, 1'b0, 1'b0);
    cas_up();
    col_write(8'd6, 1'b1);
    expect_out("R9 page early write off", 1'b0, 1'b0, 1'b0);
    cas_up();
    col_read(8'd6);
    expect_out("R9 page reread col6", 1'b1, 1'b0, 1'b1);
    close_all();

    // R5 read-modify-write
    open_row(8'd7); col_read(8'd5);
    expect_out("R5 old value before modify", 1'b1, 1'b0, 1'b0);
    din = 1'b1; we_n = 1'b0; cyc(6);
    expect_out("R5 old value kept after write", 1'b1, 1'b0, 1'b0);
    close_all();
    read_check("R5 new value stored", 8'd7, 8'd5, 1'b1);

    // R6 delayed write: write enable one clock after column strobe
    open_row(8'd7);
    addr = 8'd6; we_n = 1'b1; cas_n = 1'b0;
    cyc(1);
    din = 1'b0; we_n = 1'b0;
    cyc(6);
    expect_out("R6 delayed write flags undefined", 1'b0, 1'b1, 1'b0);
    close_all();
    expect_out("R6 flag clears after column strobe high", 1'b0, 1'b0, 1'b0);
    read_check("R6 delayed write stored", 8'd7, 8'd6, 1'b0);

    // R7 row-only refresh and column-only cycle
    open_row(8'd2); cyc(4);
    expect_out("R7 row-only refresh off", 1'b0, 1'b0, 1'b0);
    close_all();
    addr = 8'd5; din = 1'b0; we_n = 1'b0; cas_n = 1'b0; cyc(6);
    expect_out("R7 column-only off", 1'b0, 1'b0, 1'b0);
    close_all();
    read_check("R7 column-only wrote nothing", 8'd2, 8'd5, 1'b1);

    // R8 hidden refresh keeps output
    open_row(8'd7); col_read(8'd6);
    expect_out("R8 read before hidden refresh", 1'b1, 1'b0, 1'b0);
    ras_n = 1'b1; cyc(4);
    expect_out("R8 output held with row strobe high", 1'b1, 1'b0, 1'b0);
    addr = 8'd2; ras_n = 1'b0; cyc(6);
    expect_out("R8 output held after hidden refresh", 1'b1, 1'b0, 1'b0);
    close_all();

    cyc(2);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule